// File: doc/BRIEF.md
# Wrapping Overwrite LIFO Stack

A synchronous last-in first-out store of byte-wide words. A push writes the input word at the slot named by a single top index and moves the index up. A pop moves the index down and registers the word it finds onto the output port. The empty and full flags come from an occupancy counter.

The block never refuses a push. Once every slot holds live data, a further push still advances the top index, which wraps from the last slot back to the first. The new word therefore lands on the oldest entry. The most recent words are always kept, and the oldest are dropped without notice. A block enable gates every operation. When both push and pop are requested together, the pop is taken first and the push fills the slot that the pop just freed.

Top module: `wrap_stack`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0 and `dout` is 0.
- R2: A pop returns the words in the reverse of the order they were pushed. The popped word appears on `dout` one clock edge after the pop is sampled.
- R3: `empty` is 1 exactly when no valid words are held. `full` is 1 exactly when DEPTH valid words are held (DEPTH is 4 by default).
- R4: A push while full is accepted and overwrites the oldest word. `full` stays 1, and the newest DEPTH words remain poppable.
- R5: The occupancy saturates at DEPTH. After any number of overflowing pushes, exactly DEPTH pops return data and the stack is then empty.
- R6: While `en` is 0, `push`, `pop` and `din` have no effect on `dout`, the flags or the stored contents.
- R7: A pop while empty, without a push, leaves `dout` unchanged and `empty` at 1.
- R8: Push and pop together on a non-empty stack put the current top word on `dout` and replace it with `din`. The occupancy is unchanged.
- R9: Push and pop together on an empty stack act as a push alone, and `dout` is unchanged.
- R10: `dout` holds its value in every cycle without an accepted pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Block enable; all requests are ignored when 0 |
| push | input | 1 | Push request |
| pop | input | 1 | Pop request |
| din | input | DW | Word to push |
| dout | output | DW | Last popped word, registered |
| empty | output | 1 | No valid words held |
| full | output | 1 | DEPTH valid words held |

## Verification
Every result of this block is due on the first rising edge after the request is sampled. This applies to the popped word on `dout` and to both flags, since each is a register or decodes one. The bench drives requests on the falling edge and updates its queue model at the rising edge. It then compares `dout`, `empty` and `full` 1 ns later, so each comparison sees exactly one edge's worth of effect. Directed sequences cover the overflow, empty-pop, disabled and simultaneous cases, and a long mixed random run follows them.

// File: rtl/wrap_stack.sv
module wrap_stack #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] top, top_dn, top_up;
  logic [CW-1:0] cnt;

  assign empty  = (cnt == '0);
  assign full   = (cnt == CW'(DEPTH));
  assign top_dn = (top == '0) ? AW'(DEPTH - 1) : top - 1'b1;
  assign top_up = (top == AW'(DEPTH - 1)) ? '0 : top + 1'b1;

  wire do_pop  = en & pop & ~empty;
  wire do_push = en & push;

  always_ff @(posedge clk)
    if (do_push) mem[do_pop ? top_dn : top] <= din;

  always_ff @(posedge clk) begin
    if (rst) begin
      top  <= '0;
      cnt  <= '0;
      dout <= '0;
    end else begin
      if (do_pop) dout <= mem[top_dn];
      if (do_pop && !do_push) begin
        top <= top_dn;
        cnt <= cnt - 1'b1;
      end else if (do_push && !do_pop) begin
        top <= top_up;
        if (!full) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

module wrap_stack_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          push,
  input logic          pop,
  input logic [DW-1:0] dout,
  input logic          empty,
  input logic          full
);
  always_ff @(posedge clk)
    if (!rst && $past(rst))
      assert_reset_state_R1: assert (empty && !full && dout == '0);

  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));

  assert_full_stays_R4: assert property (@(posedge clk) disable iff (rst)
    (en && push && !pop && full) |=> full);

  assert_push_fills_R3: assert property (@(posedge clk) disable iff (rst)
    (en && push && !pop) |=> !empty);

  assert_idle_when_off_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(dout) && $stable(empty) && $stable(full)));

  assert_empty_pop_R7: assert property (@(posedge clk) disable iff (rst)
    (en && pop && !push && empty) |=> (empty && $stable(dout)));

  assert_swap_keeps_level_R8: assert property (@(posedge clk) disable iff (rst)
    (en && push && pop && !empty) |=> ($stable(empty) && $stable(full)));

  assert_hold_dout_R10: assert property (@(posedge clk) disable iff (rst)
    !(en && pop) |=> $stable(dout));
endmodule

bind wrap_stack wrap_stack_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .en(en), .push(push), .pop(pop),
  .dout(dout), .empty(empty), .full(full)
);

// File: tb/sim_wrap_stack.sv
`timescale 1ns/1ps
module sim_wrap_stack;
  localparam int DW = 8;
  localparam int DEPTH = 4;

  logic clk = 0, rst = 1, en = 0, push = 0, pop = 0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic empty, full;

  int n_cmp = 0, n_bad = 0;
  int q[$];
  logic [DW-1:0] exp_dout = '0;

  always #2.5 clk = ~clk;

  wrap_stack #(.DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .en(en), .push(push), .pop(pop),
    .din(din), .dout(dout), .empty(empty), .full(full)
  );

  task automatic compare(string tag);
    n_cmp++;
    if (dout !== exp_dout || empty !== (q.size() == 0) || full !== (q.size() == DEPTH)) begin
      n_bad++;
      $display("FAIL %s: dout=%0h empty=%0b full=%0b expected dout=%0h empty=%0b full=%0b",
               tag, dout, empty, full, exp_dout, q.size() == 0, q.size() == DEPTH);
    end
  endtask

  task automatic step(string tag, logic e, logic pu, logic po, logic [DW-1:0] d);
    @(negedge clk);
    en = e; push = pu; pop = po; din = d;
    @(posedge clk);
    if (e) begin
      if (po && q.size() > 0) exp_dout = q.pop_back();
      if (pu) begin
        q.push_back(int'(d));
        if (q.size() > DEPTH) void'(q.pop_front());
      end
    end
    #1 compare(tag);
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1 compare("R1");
    for (int i = 0; i < 3; i++) step("R3", 1, 1, 0, 8'h10 + 8'(i));
    for (int i = 0; i < 3; i++) step("R2", 1, 0, 1, 8'h00);
    step("R7", 1, 0, 1, 8'h00);
    step("R7", 1, 0, 1, 8'h00);
    for (int i = 0; i < 3; i++) step("R6", 0, 1, 1, 8'hE0 + 8'(i));
    step("R10", 1, 0, 0, 8'h77);
    for (int i = 0; i < DEPTH; i++) step("R3", 1, 1, 0, 8'h20 + 8'(i));
    for (int i = 0; i < 3; i++) step("R4", 1, 1, 0, 8'h30 + 8'(i));
    step("R6", 0, 0, 1, 8'h00);
    for (int i = 0; i < DEPTH + 2; i++) step("R5", 1, 0, 1, 8'h00);
    step("R9", 1, 1, 1, 8'h41);
    step("R8", 1, 1, 1, 8'h42);
    step("R8", 1, 1, 1, 8'h43);
    step("R2", 1, 0, 1, 8'h00);
    step("R10", 1, 0, 0, 8'h00);
    for (int i = 0; i < 600; i++) begin
      int r = $urandom_range(0, 9);
      step("R2", r != 0, r < 6, r > 3, 8'($urandom));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule